// File: doc/BRIEF.md
# Direct-Mapped Block Cache with Write-Through Buffer

This block is a direct-mapped cache controller placed between a processor word port and a single memory port that uses a request/ready handshake. Each byte address is divided into a tag, a set index, a word offset and a byte offset. Tags and valid bits are kept in a small tag store. Data is kept in one long data store that is one word wide and is addressed by the set index concatenated with the word offset. Because of this layout, no wide word-select multiplexor is needed after the lookup.

A read that hits returns its word in the cycle it is presented. A miss stalls the processor while the whole block is fetched, one word per memory beat, and the access then completes from the cache. Writes are write-through. A write hit updates its word in place and queues the address and data in a small write buffer, which drains to memory in the background. A write miss first refills the block and then merges the word. Before any refill starts, the buffer must be empty, so a refill can never read a value that is stale in memory.

Top module: `dmc_cache`

## Requirements
- R1: After reset every valid bit is clear, so the first access to any address misses and stalls. While the processor is idle and the buffer is empty, the memory port stays quiet.
- R2: The address fields, from the top bit down, are an 18-bit tag (bits 31..14), an 8-bit set index (bits 13..6), a 4-bit word offset (bits 5..2) and a 2-bit byte offset (bits 1..0). The byte offset does not affect which word is returned. Every memory address the block issues has bits 1..0 equal to zero.
- R3: A read hits when the set's valid bit is set and its stored tag equals the address tag. A hit returns the word with cpu_stall low in the same cycle and issues no refill.
- R4: A read miss holds cpu_stall high. It then issues exactly 16 memory reads, at block base + 4*k for k = 0..15 in that order, and returns the word that now sits in memory.
- R5: An access whose set index matches a resident block but whose tag differs replaces that block. A later access to the evicted block misses again.
- R6: A write hit overwrites only the addressed word in the cache and queues the address and data. Memory receives queued writes in issue order with their exact address and data.
- R7: A write miss refills the block and then merges the written word. Later reads return the new word, and the other words of the block come from memory.
- R8: The write buffer holds 4 entries. A write hit does not stall while fewer than 4 writes are pending. With 4 pending, the write stalls until an entry retires.
- R9: A refill read is never issued while any queued write is still waiting to reach memory.
- R10: Once raised, mem_req stays high with mem_addr, mem_we and mem_wdata unchanged until the cycle in which mem_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid when cpu_req is high and cpu_stall is low |
| cpu_stall | output | 1 | Access cannot finish in this cycle |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = buffered write, 0 = refill read |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Write data for a buffered write |
| mem_rdata | input | 32 | Read data, sampled when mem_ready is high |
| mem_ready | input | 1 | Completes the current transfer this cycle |

## Verification
Repeated reads inside one loaded block separate hits from misses and show that the byte offset plays no part in word selection. Two addresses that share a set but differ in tag show that the tag compare is exact and that eviction takes place. Write hits, write misses and reads that follow them show the merge-after-refill order and the in-order delivery of buffered writes. Holding memory not-ready fills the buffer and exposes the full-buffer stall. A pseudo-random mix over four tags and four sets, run with varying memory latency, exercises drain-before-refill and request holding together.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

   typedef enum logic [1:0] {
      ST_LOOKUP = 2'd0,
      ST_DRAIN  = 2'd1,
      ST_FILL   = 2'd2
   } dmc_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/dmc_tag_array.sv
module dmc_tag_array #(
   parameter int TAG_W   = 18,
   parameter int INDEX_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INDEX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0]   lk_tag,
   output logic               lk_hit,
   input  logic               upd_en,
   input  logic [INDEX_W-1:0] upd_idx,
   input  logic [TAG_W-1:0]   upd_tag
);
   localparam int SETS = 1 << INDEX_W;

   logic [SETS-1:0]  valid_q;
   logic [TAG_W-1:0] tag_q [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (upd_en) begin
         valid_q[upd_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (upd_en) begin
         tag_q[upd_idx] <= upd_tag;
      end
   end

   assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

endmodule

// File: rtl/dmc_data_array.sv
module dmc_data_array #(
   parameter int DATA_W = 32,
   parameter int AW     = 12
) (
   input  logic              clk,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int WORDS = 1 << AW;

   logic [DATA_W-1:0] store_q [WORDS];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         store_q[wr_addr] <= wr_data;
      end
   end

   assign rd_data = store_q[rd_addr];

endmodule

// File: rtl/dmc_write_buffer.sv
module dmc_write_buffer #(
   parameter int WA_W   = 30,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [WA_W-1:0]            push_addr,
   input  logic [DATA_W-1:0]          push_data,
   input  logic                       pop,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic [WA_W-1:0]            head_addr,
   output logic [DATA_W-1:0]          head_data
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (!dmc_pkg::is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
      $error("write buffer depth must be a power of two of at least 2");
   end

   logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [WA_W-1:0]   slot_addr [DEPTH];
   logic [DATA_W-1:0] slot_data [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [WA_W-1:0]   a_q;
      logic [DATA_W-1:0] d_q;
      always_ff @(posedge clk) begin
         if (push && (wr_ptr_q == PTR_W'(i))) begin
            a_q <= push_addr;
            d_q <= push_data;
         end
      end
      assign slot_addr[i] = a_q;
      assign slot_data[i] = d_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign count     = cnt_q;
   assign head_addr = slot_addr[rd_ptr_q];
   assign head_data = slot_data[rd_ptr_q];

endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int INDEX_W  = 8,
   parameter int OFFS_W   = 4,
   parameter int WB_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_stall,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready
);
   import dmc_pkg::*;

   localparam int BYTE_W  = $clog2(DATA_W / 8);
   localparam int TAG_W   = ADDR_W - INDEX_W - OFFS_W - BYTE_W;
   localparam int WA_W    = ADDR_W - BYTE_W;
   localparam int RAM_AW  = INDEX_W + OFFS_W;
   localparam int CNT_W   = $clog2(WB_DEPTH + 1);
   localparam logic [OFFS_W-1:0] LAST_WORD = '1;
   localparam logic [CNT_W-1:0]  WB_FULL   = CNT_W'(WB_DEPTH);

   if (!is_pow2(DATA_W) || DATA_W < 16) begin : g_bad_width
      $error("data width must be a power of two of at least 16 bits");
   end
   if (TAG_W < 1) begin : g_bad_split
      $error("address too narrow for index and offset fields");
   end

   // address fields of the current processor access
   logic [TAG_W-1:0]   req_tag;
   logic [INDEX_W-1:0] req_idx;
   logic [OFFS_W-1:0]  req_off;
   logic               unused_byte_bits;

   assign req_tag          = cpu_addr[ADDR_W-1 -: TAG_W];
   assign req_idx          = cpu_addr[BYTE_W+OFFS_W +: INDEX_W];
   assign req_off          = cpu_addr[BYTE_W +: OFFS_W];
   assign unused_byte_bits = ^cpu_addr[BYTE_W-1:0];

   dmc_state_e         state_q, state_d;
   logic [TAG_W-1:0]   fill_tag_q;
   logic [INDEX_W-1:0] fill_idx_q;
   logic [OFFS_W-1:0]  fill_cnt_q;

   logic               lk_hit;
   logic               in_lookup, in_fill;
   logic               rd_accept, wr_accept;
   logic               fill_beat, fill_last;
   logic [CNT_W-1:0]   wb_count;
   logic               wb_empty, wb_full, wb_pop;
   logic [WA_W-1:0]    wb_head_addr;
   logic [DATA_W-1:0]  wb_head_data;
   logic               ram_we;
   logic [RAM_AW-1:0]  ram_waddr;
   logic [DATA_W-1:0]  ram_wdata;

   assign in_lookup = (state_q == ST_LOOKUP);
   assign in_fill   = (state_q == ST_FILL);
   assign wb_empty  = (wb_count == '0);
   assign wb_full   = (wb_count == WB_FULL);

   assign rd_accept = in_lookup && cpu_req && !cpu_we && lk_hit;
   assign wr_accept = in_lookup && cpu_req && cpu_we && lk_hit && !wb_full;
   assign cpu_stall = cpu_req && !(rd_accept || wr_accept);

   assign fill_beat = in_fill && mem_ready;
   assign fill_last = fill_beat && (fill_cnt_q == LAST_WORD);
   assign wb_pop    = !in_fill && !wb_empty && mem_ready;

   // memory port: refill owns it in FILL, the write buffer otherwise
   assign mem_req   = in_fill || !wb_empty;
   assign mem_we    = !in_fill && !wb_empty;
   assign mem_addr  = in_fill ? {fill_tag_q, fill_idx_q, fill_cnt_q, {BYTE_W{1'b0}}}
                              : {wb_head_addr, {BYTE_W{1'b0}}};
   assign mem_wdata = wb_head_data;

   // one write port on the data store, shared by refill and write hits
   assign ram_we    = fill_beat || wr_accept;
   assign ram_waddr = fill_beat ? {fill_idx_q, fill_cnt_q} : {req_idx, req_off};
   assign ram_wdata = fill_beat ? mem_rdata : cpu_wdata;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_LOOKUP: if (cpu_req && !lk_hit) state_d = wb_empty ? ST_FILL : ST_DRAIN;
         ST_DRAIN:  if (wb_empty)           state_d = ST_FILL;
         ST_FILL:   if (fill_last)          state_d = ST_LOOKUP;
         default:                           state_d = ST_LOOKUP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_LOOKUP;
         fill_cnt_q <= '0;
         fill_tag_q <= '0;
         fill_idx_q <= '0;
      end else begin
         state_q <= state_d;
         if (in_lookup && cpu_req && !lk_hit) begin
            fill_tag_q <= req_tag;
            fill_idx_q <= req_idx;
            fill_cnt_q <= '0;
         end else if (fill_beat) begin
            fill_cnt_q <= fill_cnt_q + 1'b1;
         end
      end
   end

   dmc_tag_array #(
      .TAG_W   (TAG_W),
      .INDEX_W (INDEX_W)
   ) u_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_idx  (req_idx),
      .lk_tag  (req_tag),
      .lk_hit  (lk_hit),
      .upd_en  (fill_last),
      .upd_idx (fill_idx_q),
      .upd_tag (fill_tag_q)
   );

   dmc_data_array #(
      .DATA_W (DATA_W),
      .AW     (RAM_AW)
   ) u_data (
      .clk     (clk),
      .rd_addr ({req_idx, req_off}),
      .rd_data (cpu_rdata),
      .wr_en   (ram_we),
      .wr_addr (ram_waddr),
      .wr_data (ram_wdata)
   );

   dmc_write_buffer #(
      .WA_W   (WA_W),
      .DATA_W (DATA_W),
      .DEPTH  (WB_DEPTH)
   ) u_wbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_accept),
      .push_addr (cpu_addr[ADDR_W-1:BYTE_W]),
      .push_data (cpu_wdata),
      .pop       (wb_pop),
      .count     (wb_count),
      .head_addr (wb_head_addr),
      .head_data (wb_head_data)
   );

endmodule

// File: rtl/dmc_cache_chk.sv
module dmc_cache_chk #(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int WB_DEPTH = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       cpu_req,
   input logic                       cpu_we,
   input logic                       cpu_stall,
   input logic                       mem_req,
   input logic                       mem_we,
   input logic [ADDR_W-1:0]          mem_addr,
   input logic [DATA_W-1:0]          mem_wdata,
   input logic                       mem_ready,
   input logic [$clog2(WB_DEPTH+1)-1:0] wb_count,
   input logic                       in_lookup,
   input logic                       lk_hit
);
   localparam int BYTE_W = $clog2(DATA_W / 8);
   localparam int CNT_W  = $clog2(WB_DEPTH + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(WB_DEPTH);

   AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && in_lookup && !lk_hit) |-> cpu_stall); // R4

   AST_FULL_WRITE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we && wb_count == FULL) |-> cpu_stall); // R8

   AST_NO_WB_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wb_count <= FULL); // R8

   AST_FILL_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (wb_count == '0)); // R9

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata))); // R10

   AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[BYTE_W-1:0] == '0)); // R2

   AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_lookup && wb_count == '0) |-> !mem_req); // R1

endmodule

bind dmc_cache dmc_cache_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .WB_DEPTH (WB_DEPTH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_req   (cpu_req),
   .cpu_we    (cpu_we),
   .cpu_stall (cpu_stall),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ready (mem_ready),
   .wb_count  (wb_count),
   .in_lookup (in_lookup),
   .lk_hit    (lk_hit)
);

// File: tb/dmc_cache_tb.sv
module dmc_cache_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_stall;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ready = 1'b0;

   always #4 clk = ~clk;

   dmc_cache u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ready(mem_ready)
   );

   int tests = 0, fails = 0, cyc = 0;
   logic [31:0] mmem [int unsigned];
   logic [31:0] gold [int unsigned];
   logic [63:0] wq [$];
   logic [17:0] mtag [256];
   bit          mval [256];
   bit          mem_hold = 1'b0;
   int          lat_seq = 0, wait_cnt = 0, fill_k = 0;
   logic [31:0] fill_base = '0;
   bit          waiting = 1'b0;
   logic [31:0] wait_addr = '0;
   logic        wait_we = 1'b0;

   function automatic logic [31:0] init_word(input logic [31:0] a);
      return {a[31:2], 2'b00} ^ 32'h5A3C_0F00;
   endfunction

   function automatic logic [31:0] mem_val(input logic [31:0] a);
      return mmem.exists(a) ? mmem[a] : init_word(a);
   endfunction

   function automatic logic [31:0] gold_val(input logic [31:0] a);
      return gold.exists(a) ? gold[a] : init_word(a);
   endfunction

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic report();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         tests++; fails++;
         $display("FAIL R10 watchdog: actual %0d cycles expected completion", cyc);
         report();
      end
   end

   // memory model: variable latency, checks order, alignment and drain (R4 R6 R9 R10)
   always @(negedge clk) begin
      logic [31:0] wa;
      mem_ready = 1'b0;
      if (rst_n && waiting && mem_req)
         check(mem_addr == wait_addr && mem_we == wait_we, "R10", "request held", mem_addr, wait_addr);
      if (rst_n && mem_req && !mem_hold) begin
         if (wait_cnt >= (lat_seq % 3)) begin
            wait_cnt = 0; lat_seq++; mem_ready = 1'b1;
            wa = {mem_addr[31:2], 2'b00};
            if (mem_we) begin
               if (wq.size() == 0) check(1'b0, "R6", "unexpected memory write", mem_addr, 32'h0);
               else begin
                  check(wq[0] == {wa, mem_wdata}, "R6", "write order/address", mem_addr, wq[0][63:32]);
                  check(wq[0][31:0] == mem_wdata, "R6", "write data", mem_wdata, wq[0][31:0]);
                  void'(wq.pop_front());
               end
               mmem[wa] = mem_wdata;
            end else begin
               check(wq.size() == 0, "R9", "refill with writes pending", wq.size(), 32'h0);
               check(wa == fill_base + 4 * fill_k, "R4", "refill address", wa, fill_base + 4 * fill_k);
               mem_rdata = mem_val(wa);
               fill_k++;
            end
         end else wait_cnt++;
      end
      waiting   = mem_req && !mem_ready;
      wait_addr = mem_addr;
      wait_we   = mem_we;
   end

   // exp_first: 0/1 checked, -1 skipped, -2 derived from the bench tag model
   task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                         input int exp_first, input string rq);
      int          idx = int'(a[13:6]);
      logic [17:0] tg  = a[31:14];
      logic [31:0] wa  = {a[31:2], 2'b00};
      bit          hit = mval[idx] && (mtag[idx] == tg);
      int          ef  = exp_first;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      fill_base = {a[31:6], 6'b0}; fill_k = 0;
      #1;
      if (ef == -2) begin
         if (!hit) ef = 1;
         else if (!we || wq.size() <= 2) ef = 0;
         else if (wq.size() == 4) ef = 1;
         else ef = -1;
      end
      if (ef >= 0) check(cpu_stall == ef[0], rq, "first-cycle stall", cpu_stall, ef);
      while (cpu_stall) begin @(negedge clk); #1; end
      if (!hit) begin
         check(fill_k == 16, "R4", "refill beat count", fill_k, 16);
         mtag[idx] = tg; mval[idx] = 1'b1;
      end else check(fill_k == 0, "R3", "no refill on hit", fill_k, 0);
      if (we) begin
         gold[wa] = d;
         wq.push_back({wa, d});
      end else check(cpu_rdata == gold_val(wa), rq, "read data", cpu_rdata, gold_val(wa));
   endtask

   task automatic idle(input int n);
      @(negedge clk); cpu_req = 1'b0; cpu_we = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int unsigned seed = 32'h1234_5678;
      repeat (4) @(negedge clk);
      check(cpu_stall == 1'b0, "R1", "stall in reset", cpu_stall, 0);
      check(mem_req == 1'b0, "R1", "memory quiet in reset", mem_req, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(mem_req == 1'b0, "R1", "memory quiet after reset", mem_req, 0);

      access(1'b0, 32'h0000_0010, 0, -2, "R1");           // cold miss
      access(1'b0, 32'h0000_0000, 0, 0, "R3");
      access(1'b0, 32'h0000_003C, 0, 0, "R3");
      access(1'b0, 32'h0000_0024, 0, 0, "R3");
      access(1'b0, 32'h0000_0013, 0, 0, "R2");            // byte offset ignored
      access(1'b0, 32'h0000_4010, 0, 1, "R5");            // same set, other tag
      access(1'b0, 32'h0000_0010, 0, 1, "R5");            // evicted block misses again
      access(1'b1, 32'h0000_0020, 32'hCAFE_0020, 0, "R6");
      access(1'b0, 32'h0000_0020, 0, 0, "R6");
      access(1'b1, 32'h0001_0084, 32'hBEEF_0084, 1, "R7");
      access(1'b0, 32'h0001_0084, 0, 0, "R7");
      access(1'b0, 32'h0001_0088, 0, 0, "R7");
      idle(1);
      while (wq.size() != 0) @(negedge clk);
      idle(3);

      mem_hold = 1'b1;
      access(1'b1, 32'h0000_0000, 32'h1111_0000, 0, "R8");
      access(1'b1, 32'h0000_0004, 32'h1111_0004, 0, "R8");
      access(1'b1, 32'h0000_0008, 32'h1111_0008, 0, "R8");
      access(1'b1, 32'h0000_000C, 32'h1111_000C, 0, "R8");
      fork
         access(1'b1, 32'h0000_0010, 32'h1111_0010, 1, "R8");
         begin
            repeat (6) @(negedge clk);
            #2 check(cpu_stall == 1'b1, "R8", "stall held while full", cpu_stall, 1);
            mem_hold = 1'b0;
         end
      join
      access(1'b1, 32'h0000_0024, 32'h2222_0024, -2, "R9");
      access(1'b0, 32'h0000_8040, 0, 1, "R9");            // miss must wait for drain
      access(1'b0, 32'h0000_000C, 0, 0, "R6");

      for (int n = 0; n < 300; n++) begin
         logic [31:0] a;
         seed = seed * 32'd1664525 + 32'd1013904223;
         a = {16'h0, seed[25:24], 6'h0, seed[21:20], seed[19:16], 2'b00};
         a = {14'h0, seed[25:24], 8'h0, seed[21:20], seed[19:16], 2'b00};
         access(seed[9:8] == 2'b00, a, seed ^ 32'h0F0F_A5A5, -2, "R5");
      end
      idle(1);
      while (wq.size() != 0) @(negedge clk);
      idle(4);
      check(mem_req == 1'b0, "R1", "memory quiet when idle", mem_req, 0);
      report();
   end

endmodule